// File: doc/BRIEF.md
# Serial Port with Overlaid Control and Status

A byte-wide, memory-mapped asynchronous serial port. A processor sees two register slots. Slot 0 is the data slot: a write hands a byte to the transmitter, and a read returns the byte held in the one-byte receive buffer. Slot 1 is the control/status slot. It is write-only control and read-only status at the same address, so software never reads back what it wrote. Control picks the line rate, enables the two interrupt lines and drives a request-to-send output. Software lowers that output to make the far end hold its transmission and raises it to let the far end send.

Frames are 8N1: a start bit, eight data bits least-significant first, and a stop bit. The rate is set by an oversampling tick whose period is `BASE_DIV << speed` clocks. Sixteen ticks make one bit. The receiver takes each bit in its middle and keeps one byte. A byte that arrives while the buffer is still full is dropped and marked as an overrun.

Top module: `sio_port`

## Requirements
- R1: After reset, `line_tx` is 1, `rts` is 0, both interrupt lines are 0, `bus_rdata` is 0, and the first status read returns 0x40.
- R2: Writes to slot 1 load control and reads of slot 1 return status. Control layout: bit 0 is request-to-send, bit 1 enables the transmit-empty interrupt, bit 2 enables the receive-full interrupt, and bits 3 and up (SPEED_W bits) hold the speed. Status layout: bit 0 is overrun, bit 5 is receive-full, bit 6 is transmitter-empty, and all other bits are 0.
- R3: `rts` equals control bit 0 from the clock edge that accepts the control write onwards.
- R4: A write to slot 0 while the transmitter is idle drives `line_tx` low at the accepting edge. The line then carries the start bit, the eight data bits least-significant first and a stop bit of 1, each lasting 16·D cycles with D = BASE_DIV << speed. Transmitter-empty reads 0 for the 160·D cycles of the frame, and the line then stays at 1.
- R5: A write to slot 0 while a frame is in progress has no effect on the frame being sent.
- R6: Each step up in speed doubles D. Speed 1 therefore runs at half the rate of speed 0.
- R7: For a well-formed frame on `line_rx`, receive-full is set 152·D+3 clock edges after the first edge that samples the low start level, and the byte is stored in the buffer.
- R8: A slot-0 read returns the buffered byte and clears receive-full at that edge.
- R9: A byte that completes while receive-full is set is discarded and sets overrun. A status read returns the overrun value and then clears it.
- R10: `irq_rxfull` equals (receive-full interrupt enable AND receive-full), delayed by one clock.
- R11: `irq_txempty` equals (transmit-empty interrupt enable AND transmitter idle), delayed by one clock.
- R12: `bus_rdata` is loaded at the edge that accepts a read and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_reg | input | 1 | Slot select: 0 = data, 1 = control/status |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| line_tx | output | 1 | Serial transmit line |
| line_rx | input | 1 | Serial receive line |
| rts | output | 1 | Request-to-send to the far end |
| irq_rxfull | output | 1 | Receive-buffer-full interrupt |
| irq_txempty | output | 1 | Transmitter-empty interrupt |

## Verification
Read data, control and `rts` are due at the edge that accepts the access. The interrupt lines follow the flags one edge later. A transmit bit changes every 16·D edges counted from the accepting edge. A received byte lands 152·D+3 edges after the first edge that samples the low start level, counting both synchroniser stages and the one-cycle handover from receiver to buffer. The bench model places every expected change on the edge number given by these rules. It drives inputs 1 ns after a rising edge and compares all outputs at the falling edge of every cycle, so each result is checked in exactly the cycle it is due.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int BYTE_W      = 8;
  localparam int OVS         = 16;
  localparam int CTL_RTS     = 0;
  localparam int CTL_TXIE    = 1;
  localparam int CTL_RXIE    = 2;
  localparam int CTL_SPD_LSB = 3;
  localparam int STS_OVR     = 0;
  localparam int STS_RXF     = 5;
  localparam int STS_TXE     = 6;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_t;
endpackage

// File: rtl/sio_baud.sv
module sio_baud #(
  parameter int BASE_DIV = 2,
  parameter int SPEED_W  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               restart,
  input  logic [SPEED_W-1:0] speed,
  output logic               tick
);
  localparam int MAXDIV = BASE_DIV << ((1 << SPEED_W) - 1);
  localparam int CW     = $clog2(MAXDIV + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  always_comb begin
    lim  = CW'(BASE_DIV) << speed;
    tick = (cnt == lim - CW'(1));
  end

  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else if (tick)      cnt <= '0;
    else                cnt <= cnt + CW'(1);
  end

  AST_TICK_WRAP: assert property (@(posedge clk) disable iff (rst)
    (tick && !restart) |=> (cnt == '0)); // R6
endmodule

// File: rtl/sio_tx.sv
module sio_tx #(
  parameter int BASE_DIV = 2,
  parameter int SPEED_W  = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start,
  input  logic [sio_pkg::BYTE_W-1:0] data,
  input  logic [SPEED_W-1:0]         speed,
  output logic                       line,
  output logic                       busy
);
  import sio_pkg::*;

  logic         accept;
  logic         tick;
  logic [3:0]   sub;
  logic [3:0]   bidx;
  logic [BYTE_W+1:0] frame;

  assign accept = start && !busy;

  sio_baud #(.BASE_DIV(BASE_DIV), .SPEED_W(SPEED_W)) u_baud (
    .clk(clk), .rst(rst), .restart(accept), .speed(speed), .tick(tick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      frame <= '1;
      line  <= 1'b1;
      busy  <= 1'b0;
      sub   <= '0;
      bidx  <= '0;
    end else if (accept) begin
      frame <= {1'b1, data, 1'b0};
      line  <= 1'b0;
      busy  <= 1'b1;
      sub   <= '0;
      bidx  <= '0;
    end else if (busy && tick) begin
      if (sub == 4'(OVS - 1)) begin
        sub <= '0;
        if (bidx == 4'(BYTE_W + 1)) begin
          busy <= 1'b0;
          line <= 1'b1;
        end else begin
          bidx  <= bidx + 4'd1;
          frame <= {1'b1, frame[BYTE_W+1:1]};
          line  <= frame[1];
        end
      end else begin
        sub <= sub + 4'd1;
      end
    end
  end

  AST_TX_IDLE_MARK: assert property (@(posedge clk) disable iff (rst)
    !busy |-> line); // R4
  AST_TX_START_LOW: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (!line && busy)); // R4
  AST_TX_WR_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (start && busy && !tick) |=> $stable(frame)); // R5
endmodule

// File: rtl/sio_rx.sv
module sio_rx #(
  parameter int BASE_DIV = 2,
  parameter int SPEED_W  = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       line,
  input  logic [SPEED_W-1:0]         speed,
  output logic                       valid,
  output logic [sio_pkg::BYTE_W-1:0] data
);
  import sio_pkg::*;

  logic      s1, s2;
  logic      tick;
  logic      restart;
  rx_state_t state;
  logic [3:0] sub;
  logic [2:0] bidx;

  assign restart = (state == RX_IDLE) && !s2;

  sio_baud #(.BASE_DIV(BASE_DIV), .SPEED_W(SPEED_W)) u_baud (
    .clk(clk), .rst(rst), .restart(restart), .speed(speed), .tick(tick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= line;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= RX_IDLE;
      sub   <= '0;
      bidx  <= '0;
      data  <= '0;
      valid <= 1'b0;
    end else begin
      valid <= 1'b0;
      case (state)
        RX_IDLE: begin
          if (!s2) begin
            state <= RX_START;
            sub   <= '0;
          end
        end
        RX_START: begin
          if (tick) begin
            if (sub == 4'(OVS / 2 - 1)) begin
              sub   <= '0;
              bidx  <= '0;
              state <= s2 ? RX_IDLE : RX_DATA;
            end else begin
              sub <= sub + 4'd1;
            end
          end
        end
        RX_DATA: begin
          if (tick) begin
            if (sub == 4'(OVS - 1)) begin
              sub  <= '0;
              data <= {s2, data[BYTE_W-1:1]};
              if (bidx == 3'(BYTE_W - 1)) state <= RX_STOP;
              else                        bidx  <= bidx + 3'd1;
            end else begin
              sub <= sub + 4'd1;
            end
          end
        end
        default: begin
          if (tick) begin
            if (sub == 4'(OVS - 1)) begin
              sub   <= '0;
              state <= RX_IDLE;
              valid <= s2;
            end else begin
              sub <= sub + 4'd1;
            end
          end
        end
      endcase
    end
  end

  AST_RX_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid); // R7
  AST_RX_IDLE_AFTER: assert property (@(posedge clk) disable iff (rst)
    valid |-> (state == RX_IDLE)); // R7
endmodule

// File: rtl/sio_port.sv
module sio_port #(
  parameter int BASE_DIV = 2,
  parameter int SPEED_W  = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_en,
  input  logic       bus_we,
  input  logic       bus_reg,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       line_tx,
  input  logic       line_rx,
  output logic       rts,
  output logic       irq_rxfull,
  output logic       irq_txempty
);
  import sio_pkg::*;

  logic               wr_data, wr_ctl, rd_data, rd_stat;
  logic               ctl_txie, ctl_rxie;
  logic [SPEED_W-1:0] ctl_spd;
  logic               tx_busy;
  logic               rx_valid;
  logic [BYTE_W-1:0]  rx_byte;
  logic [BYTE_W-1:0]  rx_buf;
  logic               rx_full;
  logic               rx_ovr;
  logic [7:0]         sts;

  assign wr_data = bus_en &&  bus_we && !bus_reg;
  assign wr_ctl  = bus_en &&  bus_we &&  bus_reg;
  assign rd_data = bus_en && !bus_we && !bus_reg;
  assign rd_stat = bus_en && !bus_we &&  bus_reg;

  sio_tx #(.BASE_DIV(BASE_DIV), .SPEED_W(SPEED_W)) u_tx (
    .clk(clk), .rst(rst), .start(wr_data), .data(bus_wdata),
    .speed(ctl_spd), .line(line_tx), .busy(tx_busy)
  );

  sio_rx #(.BASE_DIV(BASE_DIV), .SPEED_W(SPEED_W)) u_rx (
    .clk(clk), .rst(rst), .line(line_rx), .speed(ctl_spd),
    .valid(rx_valid), .data(rx_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rts      <= 1'b0;
      ctl_txie <= 1'b0;
      ctl_rxie <= 1'b0;
      ctl_spd  <= '0;
    end else if (wr_ctl) begin
      rts      <= bus_wdata[CTL_RTS];
      ctl_txie <= bus_wdata[CTL_TXIE];
      ctl_rxie <= bus_wdata[CTL_RXIE];
      ctl_spd  <= bus_wdata[CTL_SPD_LSB +: SPEED_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_buf  <= '0;
      rx_full <= 1'b0;
      rx_ovr  <= 1'b0;
    end else begin
      if (rd_data) rx_full <= 1'b0;
      if (rd_stat) rx_ovr  <= 1'b0;
      if (rx_valid) begin
        if (rx_full) begin
          rx_ovr <= 1'b1;
        end else begin
          rx_buf  <= rx_byte;
          rx_full <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    sts          = '0;
    sts[STS_OVR] = rx_ovr;
    sts[STS_RXF] = rx_full;
    sts[STS_TXE] = !tx_busy;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata   <= '0;
      irq_rxfull  <= 1'b0;
      irq_txempty <= 1'b0;
    end else begin
      if (rd_stat)      bus_rdata <= sts;
      else if (rd_data) bus_rdata <= rx_buf;
      irq_rxfull  <= ctl_rxie && rx_full;
      irq_txempty <= ctl_txie && !tx_busy;
    end
  end

  AST_RXF_SET: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !rx_full) |=> (rx_full && rx_buf == $past(rx_byte))); // R7
  AST_OVR_DISCARD: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_full) |=> (rx_ovr && $stable(rx_buf))); // R9
  AST_IRQ_RX_OFF: assert property (@(posedge clk) disable iff (rst)
    !(ctl_rxie && rx_full) |=> !irq_rxfull); // R10
  AST_IRQ_TX_ON: assert property (@(posedge clk) disable iff (rst)
    (ctl_txie && !tx_busy) |=> irq_txempty); // R11
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(bus_en && !bus_we) |=> $stable(bus_rdata)); // R12
endmodule

// File: tb/sio_port_bench.sv
`timescale 1ns/1ps
module sio_port_bench;
  localparam int BASE = 2;
  localparam int SPW  = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_en = 1'b0, bus_we = 1'b0, bus_reg = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       line_tx, rts, irq_rxfull, irq_txempty;
  logic       line_rx = 1'b1;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int spd    = 0;

  always #2.5 clk = ~clk;

  sio_port #(.BASE_DIV(BASE), .SPEED_W(SPW)) u_sio_port (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we), .bus_reg(bus_reg),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .line_tx(line_tx),
    .line_rx(line_rx), .rts(rts), .irq_rxfull(irq_rxfull),
    .irq_txempty(irq_txempty)
  );

  // behavioural reference model
  int   cyc;
  bit   m_rts, m_txie, m_rxie;
  int   m_spd;
  bit   m_full, m_ovr, m_busy, m_irx, m_itx;
  logic [7:0] m_buf, m_rdata;
  logic [9:0] m_frame;
  int   m_start, m_bitc;
  int   dq[$];
  logic [7:0] bq[$];

  always @(posedge clk) begin
    if (rst) begin
      cyc = 0; m_rts = 0; m_txie = 0; m_rxie = 0; m_spd = 0;
      m_full = 0; m_ovr = 0; m_busy = 0; m_irx = 0; m_itx = 0;
      m_buf = 0; m_rdata = 0; m_frame = '1; m_start = 0; m_bitc = 1;
    end else begin
      bit o_full, o_busy, dlv;
      logic [7:0] nb;
      cyc++;
      o_full = m_full; o_busy = m_busy;
      m_irx = m_rxie && m_full;
      m_itx = m_txie && !m_busy;
      if (bus_en && !bus_we)
        m_rdata = bus_reg ? {1'b0, !m_busy, m_full, 4'b0, m_ovr} : m_buf;
      if (bus_en && bus_we && bus_reg) begin
        m_rts = bus_wdata[0]; m_txie = bus_wdata[1];
        m_rxie = bus_wdata[2]; m_spd = int'(bus_wdata[4:3]);
      end
      if (bus_en && bus_we && !bus_reg && !o_busy) begin
        m_start = cyc; m_bitc = 16 * (BASE << m_spd);
        m_frame = {1'b1, bus_wdata, 1'b0};
      end
      m_busy = (cyc < m_start + 10 * m_bitc) && (m_start != 0);
      dlv = (dq.size() > 0) && (dq[0] == cyc);
      nb = 8'h00;
      if (dlv) begin void'(dq.pop_front()); nb = bq.pop_front(); end
      if (bus_en && !bus_we && !bus_reg) m_full = 0;
      if (bus_en && !bus_we &&  bus_reg) m_ovr = 0;
      if (dlv) begin
        if (o_full) m_ovr = 1;
        else begin m_buf = nb; m_full = 1; end
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // per-clock comparison at the falling edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      logic exp_tx;
      exp_tx = m_busy ? m_frame[(cyc - m_start) / m_bitc] : 1'b1;
      chk("R4 line_tx", int'(line_tx), int'(exp_tx));
      chk("R3 rts", int'(rts), int'(m_rts));
      chk("R10 irq_rxfull", int'(irq_rxfull), int'(m_irx));
      chk("R11 irq_txempty", int'(irq_txempty), int'(m_itx));
      chk("R12 bus_rdata", int'(bus_rdata), int'(m_rdata));
    end
  end

  task automatic wr(input logic r, input logic [7:0] d);
    @(posedge clk); #1;
    bus_en = 1; bus_we = 1; bus_reg = r; bus_wdata = d;
    @(posedge clk); #1;
    bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(input logic r, output logic [7:0] d);
    @(posedge clk); #1;
    bus_en = 1; bus_we = 0; bus_reg = r;
    @(posedge clk); #1;
    bus_en = 0;
    d = bus_rdata;
  endtask

  task automatic set_ctl(input bit r, input bit txie, input bit rxie, input int s);
    spd = s;
    wr(1'b1, {3'b0, 2'(s), rxie, txie, r});
  endtask

  task automatic send_rx(input logic [7:0] b);
    int bitc;
    logic [9:0] f;
    bitc = 16 * (BASE << spd);
    f = {1'b1, b, 1'b0};
    @(posedge clk); #1;
    dq.push_back(cyc + 4 + 152 * (BASE << spd));
    bq.push_back(b);
    for (int i = 0; i < 10; i++) begin
      line_rx = f[i];
      repeat (bitc) @(posedge clk);
      #1;
    end
    line_rx = 1'b1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    logic [7:0] v;
    repeat (4) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    chk("R1 line_tx reset", int'(line_tx), 1);
    chk("R1 rts reset", int'(rts), 0);
    chk("R1 irq reset", int'({irq_rxfull, irq_txempty}), 0);
    rd(1'b1, v); chk("R1 status after reset", int'(v), 8'h40);

    // R2/R3: control write, not readable back
    set_ctl(1, 0, 0, 0);
    chk("R3 rts raised", int'(rts), 1);
    rd(1'b1, v); chk("R2 status not control", int'(v), 8'h40);

    // R4/R5: transmit at speed 0, with an ignored write mid-frame
    wr(1'b0, 8'hA5);
    idle(40);
    rd(1'b1, v); chk("R4 tx busy status", int'(v), 8'h00);
    wr(1'b0, 8'h3C);
    idle(10 * 16 * BASE);
    rd(1'b1, v); chk("R5 tx idle after frame", int'(v), 8'h40);

    // R6/R11: speed 1 with tx-empty interrupt
    set_ctl(0, 1, 0, 1);
    chk("R3 rts lowered", int'(rts), 0);
    idle(2);
    chk("R11 irq_txempty idle", int'(irq_txempty), 1);
    wr(1'b0, 8'h5A);
    idle(10 * 16 * (BASE << 1) - 10);
    rd(1'b1, v); chk("R6 half rate still busy", int'(v), 8'h00);
    idle(20);
    rd(1'b1, v); chk("R6 half rate done", int'(v), 8'h40);

    // R7/R8/R10: receive at speed 1 with rx interrupt
    set_ctl(1, 0, 1, 1);
    send_rx(8'h96);
    idle(40);
    chk("R10 irq_rxfull", int'(irq_rxfull), 1);
    rd(1'b1, v); chk("R7 status rx full", int'(v), 8'h60);
    rd(1'b0, v); chk("R8 rx byte", int'(v), 8'h96);
    rd(1'b1, v); chk("R8 full cleared", int'(v), 8'h40);

    // R9: overrun
    send_rx(8'h11);
    send_rx(8'h22);
    idle(40);
    rd(1'b1, v); chk("R9 overrun set", int'(v), 8'h61);
    rd(1'b1, v); chk("R9 overrun cleared", int'(v), 8'h60);
    rd(1'b0, v); chk("R9 first byte kept", int'(v), 8'h11);

    // R7: speed 0 receive, interrupt off
    set_ctl(0, 0, 0, 0);
    send_rx(8'h01);
    idle(40);
    chk("R10 irq off", int'(irq_rxfull), 0);
    rd(1'b0, v); chk("R7 speed0 byte", int'(v), 8'h01);
    rd(1'b1, v); chk("R2 final status", int'(v), 8'h40);

    idle(5);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule